// File: doc/BRIEF.md
# Protection Region Page Overlap Sizer

This block takes the start address of one page and compares it against a set of protection regions. Each region is given as an inclusive lowest and highest byte address. For every region the block works out how many bytes of that region lie inside the page. It then returns the smallest of those counts that is not zero, together with a flag saying whether any region touched the page at all. A translation cache uses the result to install a mapping finer than a page, so that a region boundary never falls inside a single cached entry. When the flag is set, the caller aligns both the virtual and the physical address down by masking with the size minus one. When the flag is clear, the caller keeps the normal page size.

Requests arrive on a valid/ready channel that carries the page address. The region bounds are sampled in the cycle a request is accepted. The result comes back on a second valid/ready channel, one cycle after acceptance. The result register holds its value until the consumer takes it. While it is full and not being taken, `req_ready` stays low, so back-pressure passes straight through to the requester. The sizing logic is combinational, and only the result stage is registered.

Top module: `pmp_page_overlap`

## Requirements
- R1: The page covers the addresses from `req_page` through `req_page + PAGE_BYTES - 1`, and both ends count as inside.
- R2: A region whose low bound is at or above the page start and whose high bound is at or below the page end contributes high − low + 1 bytes.
- R3: A region that is not covered by R2, starts inside the page and ends at or past the page end contributes page end − region low + 1 bytes.
- R4: A region that is not covered by R2 or R3, ends inside the page and starts at or before the page start contributes region high − page start + 1 bytes.
- R5: Any other region contributes zero. This includes a region that starts before the page and ends after it, and a region that does not touch the page.
- R6: `rsp_size` is the smallest non-zero contribution over all regions.
- R7: `rsp_hit` is 1 exactly when at least one region contributes a non-zero count. With no hit, `rsp_size` is 0.
- R8: A request accepted on a rising edge (`req_valid && req_ready`) gives `rsp_valid` high after that same edge, with the result for the page and region bounds that were present at acceptance.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_hit` and `rsp_size` hold, and `req_ready` is low.
- R10: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_page | input | ADDR_W | Page start address |
| region_lo | input | NUM_REG*ADDR_W | Inclusive low bound of each region; region i sits at bits [i*ADDR_W +: ADDR_W] |
| region_hi | input | NUM_REG*ADDR_W | Inclusive high bound of each region, packed the same way |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | At least one region overlaps the page |
| rsp_size | output | $clog2(PAGE_BYTES)+1 | Smallest non-zero overlap in bytes, or 0 |

## Verification
Every result is due exactly one rising edge after the edge on which its request is accepted. The bench drives each request on a falling edge and sees it taken on the next rising edge. It reads `rsp_valid`, `rsp_hit` and `rsp_size` on the falling edge that follows. For the back-pressure case, the bench keeps `rsp_ready` low across several edges and checks that the result and `req_ready` stay unchanged on each falling edge, before it releases the response.

// File: rtl/pmp_ovl_pkg.sv
package pmp_ovl_pkg;

  // Which overlap rule matched for one region, in priority order.
  typedef enum logic [1:0] {
    OVL_NONE   = 2'd0,
    OVL_INSIDE = 2'd1,
    OVL_HEAD   = 2'd2,
    OVL_TAIL   = 2'd3
  } ovl_kind_e;

  function automatic int unsigned size_width(input int unsigned page_bytes);
    return $clog2(page_bytes) + 1;
  endfunction

endpackage

// File: rtl/pmp_ovl_slice.sv
// Overlap byte count between one inclusive region and one inclusive page.
module pmp_ovl_slice
  import pmp_ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = 34,
  parameter int unsigned SIZE_W = 13
) (
  input  logic [ADDR_W-1:0] page_lo,
  input  logic [ADDR_W-1:0] page_hi,
  input  logic [ADDR_W-1:0] reg_lo,
  input  logic [ADDR_W-1:0] reg_hi,
  output ovl_kind_e         kind,
  output logic [SIZE_W-1:0] bytes
);

  logic lo_in_page;
  logic hi_in_page;
  logic [ADDR_W-1:0] span;

  assign lo_in_page = (reg_lo >= page_lo) && (reg_lo <= page_hi);
  assign hi_in_page = (reg_hi <= page_hi) && (reg_hi >= page_lo);

  // First matching rule wins; the order is fixed.
  always_comb begin
    kind = OVL_NONE;
    span = '0;
    if ((reg_lo >= page_lo) && (reg_hi <= page_hi)) begin
      kind = OVL_INSIDE;
      span = reg_hi - reg_lo;
    end else if (lo_in_page && (reg_hi >= page_hi)) begin
      kind = OVL_HEAD;
      span = page_hi - reg_lo;
    end else if (hi_in_page && (reg_lo <= page_lo)) begin
      kind = OVL_TAIL;
      span = reg_hi - page_lo;
    end
  end

  assign bytes = (kind == OVL_NONE) ? '0 : (span[SIZE_W-1:0] + 1'b1);

endmodule

// File: rtl/pmp_ovl_minsel.sv
// Smallest non-zero value across all lanes, plus a found flag.
module pmp_ovl_minsel #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned SIZE_W = 13
) (
  input  logic [LANES*SIZE_W-1:0] lane_bytes,
  output logic                    any_hit,
  output logic [SIZE_W-1:0]       min_bytes
);

  always_comb begin
    logic [SIZE_W-1:0] cur;
    any_hit   = 1'b0;
    min_bytes = '0;
    for (int i = 0; i < LANES; i++) begin
      cur = lane_bytes[i*SIZE_W +: SIZE_W];
      if ((cur != '0) && (!any_hit || (cur < min_bytes))) begin
        min_bytes = cur;
        any_hit   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pmp_page_overlap.sv
module pmp_page_overlap
  import pmp_ovl_pkg::*;
#(
  parameter int unsigned NUM_REG    = 16,
  parameter int unsigned ADDR_W     = 34,
  parameter int unsigned PAGE_BYTES = 4096,
  localparam int unsigned SIZE_W    = size_width(PAGE_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_page,
  input  logic [NUM_REG*ADDR_W-1:0] region_lo,
  input  logic [NUM_REG*ADDR_W-1:0] region_hi,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic                      rsp_hit,
  output logic [SIZE_W-1:0]         rsp_size
);

  localparam logic [ADDR_W-1:0] PAGE_LAST = ADDR_W'(PAGE_BYTES - 1);

  logic [ADDR_W-1:0]         page_end;
  logic [NUM_REG*SIZE_W-1:0] all_bytes;
  logic                      found;
  logic [SIZE_W-1:0]         smallest;
  logic                      take;

  assign page_end = req_page + PAGE_LAST;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_region
    ovl_kind_e kind_unused;
    pmp_ovl_slice #(
      .ADDR_W(ADDR_W),
      .SIZE_W(SIZE_W)
    ) u_slice (
      .page_lo(req_page),
      .page_hi(page_end),
      .reg_lo (region_lo[g*ADDR_W +: ADDR_W]),
      .reg_hi (region_hi[g*ADDR_W +: ADDR_W]),
      .kind   (kind_unused),
      .bytes  (all_bytes[g*SIZE_W +: SIZE_W])
    );
  end

  pmp_ovl_minsel #(
    .LANES (NUM_REG),
    .SIZE_W(SIZE_W)
  ) u_min (
    .lane_bytes(all_bytes),
    .any_hit   (found),
    .min_bytes (smallest)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_size  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= found;
      rsp_size  <= smallest;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pmp_page_overlap_chk.sv
module pmp_page_overlap_chk #(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned SIZE_W     = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [SIZE_W-1:0] rsp_size
);

  p_due_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_size)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_hit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == (rsp_size != '0)));

  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_size <= SIZE_W'(PAGE_BYTES)));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

endmodule

bind pmp_page_overlap pmp_page_overlap_chk #(
  .PAGE_BYTES(PAGE_BYTES),
  .SIZE_W    (SIZE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_hit  (rsp_hit),
  .rsp_size (rsp_size)
);

// File: tb/pmp_page_overlap_test.sv
`timescale 1ns/1ps
module pmp_page_overlap_test;

  localparam int NR = 2;
  localparam int AW = 8;
  localparam int PB = 16;
  localparam int SW = $clog2(PB) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_page = '0;
  logic [NR*AW-1:0] region_lo = '0;
  logic [NR*AW-1:0] region_hi = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_hit;
  logic [SW-1:0] rsp_size;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmp_page_overlap #(.NUM_REG(NR), .ADDR_W(AW), .PAGE_BYTES(PB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .region_lo(region_lo), .region_hi(region_hi),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_size(rsp_size)
  );

  // Expected count from plain interval intersection (R1 inclusive ends),
  // with the straddling case forced to zero (R5).
  function automatic int expect_ovl(int pg, int lo, int hi);
    int pe, a, b;
    pe = pg + PB - 1;
    if (lo < pg && hi > pe) return 0;
    a = (lo > pg) ? lo : pg;
    b = (hi < pe) ? hi : pe;
    if (b < a) return 0;
    return b - a + 1;
  endfunction

  function automatic string tag_of(int pg, int lo, int hi);
    int pe;
    pe = pg + PB - 1;
    if (expect_ovl(pg, lo, hi) == 0) return "R5";
    if (lo >= pg && hi <= pe) return "R2";
    if (lo >= pg) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int pg, int lo0, int hi0, int lo1, int hi1, string req);
    int e0, e1, em;
    e0 = expect_ovl(pg, lo0, hi0);
    e1 = expect_ovl(pg, lo1, hi1);
    em = 0;
    if (e0 != 0) em = e0;
    if (e1 != 0 && (em == 0 || e1 < em)) em = e1;
    @(negedge clk);
    req_page = AW'(pg);
    region_lo = {AW'(lo1), AW'(lo0)};
    region_hi = {AW'(hi1), AW'(hi0)};
    req_valid = 1'b1;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 valid", int'(rsp_valid), 1);
    check({req, " size"}, int'(rsp_size), em);
    check("R7 hit", int'(rsp_hit), (em != 0) ? 1 : 0);
  endtask

  initial begin
    #300000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R10 valid", int'(rsp_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid", int'(rsp_valid), 0);
    check("R10 ready", int'(req_ready), 1);

    // Sweep region 0 around the page at 0x40; region 1 stays far away.
    for (int lo = 'h30; lo < 'h60; lo++)
      for (int hi = lo; hi < 'h60; hi++)
        run('h40, lo, hi, 'h00, 'h05, tag_of('h40, lo, hi));

    // Region 0 spans the whole page exactly (R1 ends inclusive).
    run('h40, 'h40, 'h4F, 'h00, 'h05, "R1");
    // Straddles both sides.
    run('h40, 'h3F, 'h50, 'hA0, 'hB0, "R5");

    // Minimum across two regions; region 0 fixed at 8 bytes.
    for (int lo = 'h38; lo < 'h54; lo++)
      for (int hi = lo; hi < 'h54; hi += 3)
        run('h40, 'h44, 'h4B, lo, hi, "R6");

    // Other page bases.
    for (int p = 0; p < 'hF0; p += 'h30)
      run(p, p + 3, p + 5, p - 2 < 0 ? 0 : p - 2, p + 1, "R6");

    // Back-pressure.
    @(negedge clk);
    req_page = 8'h40;
    region_lo = {8'h00, 8'h42};
    region_hi = {8'h05, 8'h44};
    req_valid = 1'b1;
    rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    region_lo = {8'h00, 8'h40};
    region_hi = {8'h05, 8'h40};
    for (int k = 0; k < 4; k++) begin
      check("R9 valid", int'(rsp_valid), 1);
      check("R9 ready", int'(req_ready), 0);
      check("R9 size", int'(rsp_size), 3);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drain", int'(rsp_valid), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule